// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address through a single-level page table kept inside the block. Pages are 64 bytes. The upper eight address bits select one of 256 table entries. The low six bits are the byte offset within the page, and they are carried across unchanged. Each entry holds a present flag, a 6-bit physical page number and three permission flags: may-read, may-write and supervisor-only.

Software fills the table through a write port, one entry per cycle. A requester presents a virtual address, the kind of access (read or write) and its privilege level, using a valid/ready handshake. One cycle after a request is accepted, the block returns a response carrying a 2-bit status code. On success the response carries the physical address. If the entry is absent the status reports a missing page, and if the permissions forbid the access it reports a protection fault. In both fault cases the physical address reads zero. A reset marks every entry absent.

Top module: `pt_xlate`

## Requirements
- R1: While reset is high and on the cycle after, `req_ready` is low and `rsp_valid` is low. Reset marks all 256 entries absent, so any request accepted after reset, before any table write, returns status 01 (absent).
- R2: `req_ready` is high on every cycle whose preceding clock edge saw reset low. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge, and `rsp_valid` is high exactly in the cycle after each accepted request and low otherwise.
- R3: The page index is `req_va[13:6]` and the offset is `req_va[5:0]`. On status 00 (OK), `rsp_pa[11:6]` is the entry's page number and `rsp_pa[5:0]` equals the request offset. For example, index 0x00 mapped to 0x28 turns 0x0020 into 0xA20, and index 0x09 mapped to 0x17 turns 0x0256 into 0x5D6.
- R4: A request that hits an entry whose present flag is clear returns status 01 with `rsp_pa` zero, whatever the entry's permission flags are.
- R5: A read needs the entry's may-read flag and a write needs its may-write flag. Otherwise the status is 10 (protection) with `rsp_pa` zero. A read-only page therefore answers a read with 00 and a write with 10.
- R6: An entry with the supervisor-only flag returns status 10 to a request with `req_super` low, even when the read and write flags allow the access. With `req_super` high, the read and write flags alone decide.
- R7: Several page indices may name the same physical page number, and each of them translates to it.
- R8: A table write (`cfg_we` high at an edge, reset low) changes the result of requests accepted at later edges. A request accepted at the same edge as a write to its own entry sees the previous contents.
- R9: Status code 11 is never produced, and with `rsp_valid` low the status is 00 and `rsp_pa` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_vpn | input | 8 | Index of the entry to write |
| cfg_present | input | 1 | Present flag to store |
| cfg_rd | input | 1 | May-read flag to store |
| cfg_wr | input | 1 | May-write flag to store |
| cfg_sup | input | 1 | Supervisor-only flag to store |
| cfg_ppn | input | 6 | Physical page number to store |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 00 OK, 01 absent, 10 protection |
| rsp_pa | output | 12 | Physical address, zero unless status is OK |

## Verification
The hardest case to reach from the ports is a table write and a lookup of the same entry landing on one clock edge, where the old contents must win. The bench drives that collision on purpose and follows it at once with a second lookup that must see the new entry. Absent entries that still carry permissive flags are also written on purpose, to confirm that the present check ranks above the permission checks. A long stretch of mixed writes and lookups over a small set of indices then produces further collisions, aliases and overwrites, and every cycle is compared against a behavioural model.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_ABSENT = 2'b01,
    ST_PROT   = 2'b10
  } xlate_status_e;

  // Permission flag positions inside the stored entry word {ppn, flags}
  localparam int unsigned PERM_RD  = 0;
  localparam int unsigned PERM_WR  = 1;
  localparam int unsigned PERM_SUP = 2;
  localparam int unsigned PERM_W   = 3;

endpackage

// File: rtl/pt_table.sv
module pt_table #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_present,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_present_q,
  output logic [DATA_W-1:0] rd_data_q
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  // Present flags in flops so reset can clear them in one cycle
  logic [DEPTH-1:0]  present_bits;
  // Page number and flags in a plain array, read synchronously (RAM style)
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      present_bits <= '0;
    end else if (wr_en) begin
      present_bits[wr_addr] <= wr_present;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read-first: a same-edge write is not visible to this read
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data_q <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_present_q <= 1'b0;
    end else if (rd_en) begin
      rd_present_q <= present_bits[rd_addr];
    end
  end

  AST_WRITE_SETS_PRESENT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> present_bits[$past(wr_addr)] == $past(wr_present)); // R8

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_xlate_pkg::*;
(
  input  logic                present,
  input  logic [PERM_W-1:0]   perm,
  input  logic                is_write,
  input  logic                is_super,
  output xlate_status_e       status
);

  logic kind_denied;
  logic level_denied;

  always_comb begin
    kind_denied  = is_write ? ~perm[PERM_WR] : ~perm[PERM_RD];
    level_denied = perm[PERM_SUP] & ~is_super;
    if (!present) begin
      status = ST_ABSENT;
    end else if (kind_denied || level_denied) begin
      status = ST_PROT;
    end else begin
      status = ST_OK;
    end
  end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int unsigned VA_W  = 14,
  parameter int unsigned PA_W  = 12,
  parameter int unsigned OFF_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [VA_W-OFF_W-1:0] cfg_vpn,
  input  logic                  cfg_present,
  input  logic                  cfg_rd,
  input  logic                  cfg_wr,
  input  logic                  cfg_sup,
  input  logic [PA_W-OFF_W-1:0] cfg_ppn,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic                  req_write,
  input  logic                  req_super,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_status,
  output logic [PA_W-1:0]       rsp_pa
);

  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned ENT_W  = PPN_W + PERM_W;

  logic              accept;
  logic              tbl_we;
  logic [ENT_W-1:0]  wr_word;
  logic [ENT_W-1:0]  ent_q;
  logic              present_q;
  logic [OFF_W-1:0]  off_q;
  logic              write_q;
  logic              super_q;
  logic              rsp_valid_q;
  logic              ready_q;
  xlate_status_e     chk_status;
  xlate_status_e     out_status;

  assign accept  = req_valid & ready_q & ~rst;
  assign tbl_we  = cfg_we & ~rst;

  always_comb begin
    wr_word                = '0;
    wr_word[PERM_RD]       = cfg_rd;
    wr_word[PERM_WR]       = cfg_wr;
    wr_word[PERM_SUP]      = cfg_sup;
    wr_word[ENT_W-1:PERM_W] = cfg_ppn;
  end

  pt_table #(
    .ADDR_W (VPN_W),
    .DATA_W (ENT_W)
  ) table_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (tbl_we),
    .wr_addr      (cfg_vpn),
    .wr_present   (cfg_present),
    .wr_data      (wr_word),
    .rd_en        (accept),
    .rd_addr      (req_va[VA_W-1:OFF_W]),
    .rd_present_q (present_q),
    .rd_data_q    (ent_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      off_q       <= '0;
      write_q     <= 1'b0;
      super_q     <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= accept;
      if (accept) begin
        off_q   <= req_va[OFF_W-1:0];
        write_q <= req_write;
        super_q <= req_super;
      end
    end
  end

  pt_perm_check check_i (
    .present  (present_q),
    .perm     (ent_q[PERM_W-1:0]),
    .is_write (write_q),
    .is_super (super_q),
    .status   (chk_status)
  );

  assign out_status = rsp_valid_q ? chk_status : ST_OK;

  assign req_ready  = ready_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = out_status;
  assign rsp_pa     = (rsp_valid_q && chk_status == ST_OK) ?
                      {ent_q[ENT_W-1:PERM_W], off_q} : '0;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid); // R2

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> req_ready); // R2

  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_OK) |-> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])); // R3

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_status != 2'b11); // R9

endmodule

// File: tb/pt_xlate_tb_top.sv
module pt_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_vpn = '0;
  logic        cfg_present = 1'b0;
  logic        cfg_rd = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sup = 1'b0;
  logic [5:0]  cfg_ppn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [11:0] rsp_pa;

  always #5 clk = ~clk;

  pt_xlate dut_i (
    .clk (clk), .rst (rst),
    .cfg_we (cfg_we), .cfg_vpn (cfg_vpn), .cfg_present (cfg_present),
    .cfg_rd (cfg_rd), .cfg_wr (cfg_wr), .cfg_sup (cfg_sup), .cfg_ppn (cfg_ppn),
    .req_valid (req_valid), .req_ready (req_ready), .req_va (req_va),
    .req_write (req_write), .req_super (req_super),
    .rsp_valid (rsp_valid), .rsp_status (rsp_status), .rsp_pa (rsp_pa)
  );

  // Behavioural reference model
  bit       m_present [256];
  bit       m_rd [256];
  bit       m_wr [256];
  bit       m_sup [256];
  bit [5:0] m_ppn [256];
  bit       m_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // One clock: drive at negedge, predict, advance, compare at next negedge
  task automatic cyc(input bit r, input bit rv, input bit [13:0] va, input bit w,
                     input bit s, input bit we, input bit [7:0] wv, input bit p,
                     input bit prd, input bit pwr, input bit psup,
                     input bit [5:0] pp, input string tag);
    bit        e_v;
    bit [1:0]  e_st;
    bit [11:0] e_pa;
    bit [7:0]  vpn;
    rst = r; req_valid = rv; req_va = va; req_write = w; req_super = s;
    cfg_we = we; cfg_vpn = wv; cfg_present = p; cfg_rd = prd; cfg_wr = pwr;
    cfg_sup = psup; cfg_ppn = pp;
    e_v  = !r && rv && m_ready;
    e_st = 2'b00;
    e_pa = '0;
    if (e_v) begin
      vpn = va[13:6];
      if (!m_present[vpn]) e_st = 2'b01;
      else if ((w ? !m_wr[vpn] : !m_rd[vpn]) || (m_sup[vpn] && !s)) e_st = 2'b10;
      else begin
        e_st = 2'b00;
        e_pa = {m_ppn[vpn], va[5:0]};
      end
    end
    if (r) begin
      for (int i = 0; i < 256; i++) m_present[i] = 1'b0;
    end else if (we) begin
      m_present[wv] = p; m_rd[wv] = prd; m_wr[wv] = pwr; m_sup[wv] = psup; m_ppn[wv] = pp;
    end
    m_ready = !r;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== e_v || rsp_status !== e_st || rsp_pa !== e_pa || req_ready !== m_ready) begin
      fails++;
      $display("FAIL %s: got valid=%0b status=%02b pa=%03h ready=%0b, expected valid=%0b status=%02b pa=%03h ready=%0b",
               tag, rsp_valid, rsp_status, rsp_pa, req_ready, e_v, e_st, e_pa, m_ready);
    end
  endtask

  task automatic req(input bit [13:0] va, input bit w, input bit s, input string tag);
    cyc(1'b0, 1'b1, va, w, s, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, tag);
  endtask

  task automatic wr_ent(input bit [7:0] v, input bit p, input bit prd, input bit pwr,
                        input bit psup, input bit [5:0] pp, input string tag);
    cyc(1'b0, 1'b0, 14'h0, 1'b0, 1'b0, 1'b1, v, p, prd, pwr, psup, pp, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 14'h0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, tag);
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++)
      cyc(1'b1, 1'b1, 14'h0040, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 6'h3F, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got no end of test, expected end before timeout");
    summary();
  end

  initial begin
    @(negedge clk);
    // R1: reset state, then everything absent
    do_reset(3);
    req(14'h0020, 1'b0, 1'b1, "R1");
    req(14'h3FFF, 1'b1, 1'b1, "R1");
    req(14'h0256, 1'b0, 1'b0, "R1");
    idle("R2");
    // R3: the two worked examples
    wr_ent(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 6'h28, "R8");
    wr_ent(8'h09, 1'b1, 1'b1, 1'b1, 1'b0, 6'h17, "R8");
    req(14'h0020, 1'b0, 1'b0, "R3");
    req(14'h0256, 1'b1, 1'b0, "R3");
    req(14'h027F, 1'b0, 1'b1, "R3");
    // R4: absent entry with every permission set
    wr_ent(8'h03, 1'b0, 1'b1, 1'b1, 1'b0, 6'h11, "R8");
    req({8'h03, 6'h05}, 1'b0, 1'b1, "R4");
    req({8'h03, 6'h05}, 1'b1, 1'b0, "R4");
    // R5: read-only page and write-only page
    wr_ent(8'h05, 1'b1, 1'b1, 1'b0, 1'b0, 6'h16, "R8");
    req({8'h05, 6'h2A}, 1'b0, 1'b0, "R5");
    req({8'h05, 6'h2A}, 1'b1, 1'b1, "R5");
    wr_ent(8'h06, 1'b1, 1'b0, 1'b1, 1'b0, 6'h07, "R8");
    req({8'h06, 6'h01}, 1'b0, 1'b1, "R5");
    req({8'h06, 6'h01}, 1'b1, 1'b0, "R5");
    // R6: supervisor-only page
    wr_ent(8'h07, 1'b1, 1'b1, 1'b1, 1'b1, 6'h33, "R8");
    req({8'h07, 6'h3C}, 1'b0, 1'b0, "R6");
    req({8'h07, 6'h3C}, 1'b1, 1'b0, "R6");
    req({8'h07, 6'h3C}, 1'b0, 1'b1, "R6");
    req({8'h07, 6'h3C}, 1'b1, 1'b1, "R6");
    // R7: aliases
    wr_ent(8'h10, 1'b1, 1'b1, 1'b1, 1'b0, 6'h2A, "R8");
    wr_ent(8'hF1, 1'b1, 1'b1, 1'b1, 1'b0, 6'h2A, "R8");
    req({8'h10, 6'h0F}, 1'b0, 1'b0, "R7");
    req({8'hF1, 6'h30}, 1'b1, 1'b0, "R7");
    // R8: same-edge collision sees the old entry, next request the new one
    cyc(1'b0, 1'b1, {8'h20, 6'h04}, 1'b0, 1'b0, 1'b1, 8'h20, 1'b1, 1'b1, 1'b1, 1'b0, 6'h3E, "R8");
    req({8'h20, 6'h04}, 1'b0, 1'b0, "R8");
    cyc(1'b0, 1'b1, 14'h0256, 1'b0, 1'b0, 1'b1, 8'h09, 1'b0, 1'b1, 1'b1, 1'b0, 6'h17, "R8");
    req(14'h0256, 1'b0, 1'b0, "R8");
    // R9 / R2: idle cycles give no response
    idle("R9");
    idle("R9");
    // Mixed traffic against the model
    for (int i = 0; i < 800; i++) begin
      int unsigned k;
      bit [7:0] v;
      k = $urandom_range(0, 3);
      v = 8'($urandom_range(0, 15));
      cyc(1'b0, k != 0, {8'($urandom_range(0, 15)), 6'($urandom)}, 1'($urandom), 1'($urandom),
          k != 1, v, ($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
          1'($urandom), 6'($urandom), "R5");
    end
    // R1: reset mid-run clears the table
    do_reset(2);
    for (int v = 0; v < 16; v++) req({8'(v), 6'h11}, 1'b0, 1'b1, "R1");
    summary();
  end

endmodule